// File: doc/BRIEF.md
# Fused Multiply-Add Shader ALU

This block is a fixed-point arithmetic unit that evaluates one signed product-plus-addend per clock. It takes three signed Q8.8 operands, a, b and c. A two-bit form field chooses which of the two terms are negated. A three-bit scale field can multiply or divide the sum by a power of two before the result is narrowed. The product a·b is carried at its full Q16.16 width into the addition, so no precision is lost there. The only loss of precision happens once, at the end: the scaled sum is rounded back to Q8.8.

Results appear a fixed six cycles after they are issued, in issue order, with no stall path. The input and output streams carry a valid strobe and no ready signal. The unit never refuses an operation and never holds one back, so the consumer must accept every result in the cycle it is presented. Each result comes with two flags: an overflow flag and an inexact flag. Both describe that result alone, and both are decided only after the fused operation has completed.

Top module: `fma_shader_alu`

## Requirements
- R1: `in_form` selects the sign pattern. Bit 0 set negates the product and bit 1 set negates the addend, giving 0 = a·b+c, 1 = −a·b+c, 2 = a·b−c and 3 = −a·b−c.
- R2: The product is held exactly at Q16.16 and added to c without any intermediate rounding. The result can therefore differ from a product rounded to Q8.8 and then added to c; for example a=0x0001, b=0x0080, c=0x0001 with form 0 gives 0x0002.
- R3: `in_scale[2]` = 0 multiplies the exact sum by 2^`in_scale[1:0]`, and `in_scale[2]` = 1 divides it by 2^`in_scale[1:0]`. Codes 0 and 4 therefore leave the sum unscaled. Scaling is applied before the final rounding.
- R4: The scaled sum is rounded to Q8.8 to the nearest value, with exact ties going to the value whose least significant bit is 0.
- R5: If the rounded value is above 0x7FFF or below 0x8000 as a signed number, the output is clamped to that rail and `out_ovf` is set with it. The flag depends only on the final value, so an intermediate product outside the Q8.8 range that the addend brings back into range raises no flag.
- R6: `out_inexact` is set exactly when the final rounding discards nonzero bits, including bits shifted out by a divide scale.
- R7: An operation presented with `in_valid` high appears on the outputs with `out_valid` high six rising edges later, counting the edge that samples it. One operation is accepted every cycle, and results leave in issue order.
- R8: A synchronous active-high `rst` clears every valid bit in the pipeline. `out_valid` is low after a reset edge, and no operation issued before the reset ever emerges.
- R9: A cycle with `in_valid` low produces `out_valid` low six edges later and leaves the results of neighbouring operations unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe; no back-pressure |
| in_a | input | 16 | Multiplicand, signed Q8.8 |
| in_b | input | 16 | Multiplier, signed Q8.8 |
| in_c | input | 16 | Addend, signed Q8.8 |
| in_form | input | 2 | Sign-pattern select (R1) |
| in_scale | input | 3 | Power-of-two scale select (R3) |
| out_valid | output | 1 | Result strobe |
| out_result | output | 16 | Rounded, saturated result, signed Q8.8 |
| out_ovf | output | 1 | Result was clamped to a rail |
| out_inexact | output | 1 | Nonzero bits were discarded by rounding |

## Verification
The hardest cases to reach from the ports are those where the product lands exactly on a half unit of the last place and the addend then moves the sum to a different rounding decision. That is where the fused result and a two-step result part ways. A second hard case is a product that exceeds the Q8.8 range on its own, which a negative addend then pulls back inside. The stimulus builds both cases directly from small operands: products such as 1/256 × 0.5 that sit on a half unit, and 64 × 3 offset by −65. A sweep over edge-valued operands across all forms and scale codes then surrounds these cases with ties, rails and divide-induced inexact results. The bench model computes the exact wide sum and rounds it once, and for the divergence vectors it also confirms that a separately rounded computation would have given a different answer.

// File: rtl/fma_pkg.sv
package fma_pkg;
  // Largest shift magnitude encoded by the two amount bits of the scale field.
  localparam int SCALE_MAX = 3;

  typedef struct packed {
    logic neg_add;   // bit 1: negate the addend
    logic neg_prod;  // bit 0: negate the product
  } form_t;

  typedef struct packed {
    logic       div;  // bit 2: shift right instead of left
    logic [1:0] amt;  // bits 1:0: shift distance
  } scale_t;
endpackage

// File: rtl/fma_product.sv
module fma_product
  import fma_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            v_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [DW-1:0]   c_i,
  input  form_t           form_i,
  input  scale_t          scale_i,
  output logic            v_o,
  output logic [2*DW-1:0] prod_o,
  output logic [2*DW-1:0] addend_o,
  output form_t           form_o,
  output scale_t          scale_o
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] a_ext, b_ext, prod_d;
  logic        [PW-1:0] addend_d;

  always_comb begin
    a_ext    = {{DW{a_i[DW-1]}}, a_i};
    b_ext    = {{DW{b_i[DW-1]}}, b_i};
    prod_d   = a_ext * b_ext;
    // Align c to the product's binary point, keeping its sign.
    addend_d = {{(DW-FRAC){c_i[DW-1]}}, c_i, {FRAC{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_i;
    prod_o   <= prod_d;
    addend_o <= addend_d;
    form_o   <= form_i;
    scale_o  <= scale_i;
  end

  // The full-width product carries the sign of a XOR b whenever both factors are nonzero.
  AST_PROD_SIGN: assert property (@(posedge clk) disable iff (rst)
    (v_i && (a_i != '0) && (b_i != '0)) |=>
      (prod_o[PW-1] == ($past(a_i[DW-1]) ^ $past(b_i[DW-1])))); // R2
endmodule

// File: rtl/fma_sum_scale.sv
module fma_sum_scale
  import fma_pkg::*;
#(
  parameter int PW = 32,
  parameter int AW = PW + 3,
  parameter int EW = AW + 2 * SCALE_MAX
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [PW-1:0] prod_i,
  input  logic [PW-1:0] addend_i,
  input  form_t         form_i,
  input  scale_t        scale_i,
  output logic          v_o,
  output logic [EW-1:0] ext_o
);
  localparam int SHW = $clog2(2 * SCALE_MAX + 1);

  // Stage A: exact signed sum at the product's Q16.16 scale.
  logic signed [AW-1:0] p_ext, c_ext, p_term, c_term, sum_d, sum_q;
  logic                 v_a;
  scale_t               scale_a;

  always_comb begin
    p_ext  = {{(AW-PW){prod_i[PW-1]}}, prod_i};
    c_ext  = {{(AW-PW){addend_i[PW-1]}}, addend_i};
    p_term = form_i.neg_prod ? -p_ext : p_ext;
    c_term = form_i.neg_add  ? -c_ext : c_ext;
    sum_d  = p_term + c_term;
  end

  always_ff @(posedge clk) begin
    if (rst) v_a <= 1'b0;
    else     v_a <= v_i;
    sum_q   <= sum_d;
    scale_a <= scale_i;
  end

  // Stage B: shift left by SCALE_MAX +/- amt, so that divides keep their
  // shifted-out bits as extra fraction bits for the rounder.
  logic [SHW-1:0] sh;
  logic [EW-1:0]  ext_d;

  always_comb begin
    if (scale_a.div) sh = SHW'(SCALE_MAX) - SHW'(scale_a.amt);
    else             sh = SHW'(SCALE_MAX) + SHW'(scale_a.amt);
    ext_d = {{(EW-AW){sum_q[AW-1]}}, sum_q} << sh;
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_a;
    ext_o <= ext_d;
  end

  // Scaling never changes the sign of the sum.
  AST_SCALE_SIGN: assert property (@(posedge clk) disable iff (rst)
    v_a |=> (ext_o[EW-1] == $past(sum_q[AW-1]))); // R3
endmodule

// File: rtl/fma_round_sat.sv
module fma_round_sat #(
  parameter int EW   = 41,
  parameter int DROP = 11,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [EW-1:0] ext_i,
  output logic          v_o,
  output logic [DW-1:0] res_o,
  output logic          ovf_o,
  output logic          inexact_o
);
  localparam int RW = EW - DROP;
  localparam logic signed [RW-1:0] HI_V = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [RW-1:0] LO_V = {{(RW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // Stage A: round to nearest, ties to even.
  logic [RW-1:0]   floor_q;
  logic [DROP-1:0] rem;
  logic            up, tie_d;
  logic [RW-1:0]   rnd_d;

  always_comb begin
    floor_q = ext_i[EW-1:DROP];
    rem     = ext_i[DROP-1:0];
    up      = rem[DROP-1] & ((|rem[DROP-2:0]) | floor_q[0]);
    tie_d   = (rem == {1'b1, {(DROP-1){1'b0}}});
    rnd_d   = floor_q + {{(RW-1){1'b0}}, up};
  end

  logic          v_r, inx_r, tie_r;
  logic [RW-1:0] rnd_r;

  always_ff @(posedge clk) begin
    if (rst) v_r <= 1'b0;
    else     v_r <= v_i;
    rnd_r <= rnd_d;
    inx_r <= |rem;
    tie_r <= tie_d;
  end

  // Stage B: clamp to the output range.
  logic          hi_d, lo_d;
  logic [DW-1:0] res_d;

  always_comb begin
    hi_d = $signed(rnd_r) > HI_V;
    lo_d = $signed(rnd_r) < LO_V;
    if (hi_d)      res_d = {1'b0, {(DW-1){1'b1}}};
    else if (lo_d) res_d = {1'b1, {(DW-1){1'b0}}};
    else           res_d = rnd_r[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) v_o <= 1'b0;
    else     v_o <= v_r;
    res_o     <= res_d;
    ovf_o     <= hi_d | lo_d;
    inexact_o <= inx_r;
  end

  AST_TIE_EVEN: assert property (@(posedge clk) disable iff (rst)
    (v_r && tie_r) |-> !rnd_r[0]); // R4
  AST_SAT_RAIL: assert property (@(posedge clk) disable iff (rst)
    (v_o && ovf_o) |-> ((res_o == {1'b0, {(DW-1){1'b1}}}) || (res_o == {1'b1, {(DW-1){1'b0}}}))); // R5
endmodule

// File: rtl/fma_shader_alu.sv
module fma_shader_alu
  import fma_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  input  logic [1:0]    in_form,
  input  logic [2:0]    in_scale,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic          out_ovf,
  output logic          out_inexact
);
  localparam int PW   = 2 * DW;
  localparam int AW   = PW + SCALE_MAX;
  localparam int EW   = AW + 2 * SCALE_MAX;
  localparam int DROP = FRAC + SCALE_MAX;
  localparam int LAT  = 6;

  // Stage 1: operand capture.
  logic          v1;
  logic [DW-1:0] a1, b1, c1;
  form_t         f1;
  scale_t        s1;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    a1 <= in_a;
    b1 <= in_b;
    c1 <= in_c;
    f1 <= form_t'(in_form);
    s1 <= scale_t'(in_scale);
  end

  logic          v2;
  logic [PW-1:0] prod2, addend2;
  form_t         f2;
  scale_t        s2;

  fma_product #(.DW(DW), .FRAC(FRAC)) u_product (
    .clk(clk), .rst(rst), .v_i(v1), .a_i(a1), .b_i(b1), .c_i(c1),
    .form_i(f1), .scale_i(s1), .v_o(v2), .prod_o(prod2), .addend_o(addend2),
    .form_o(f2), .scale_o(s2)
  );

  logic          v4;
  logic [EW-1:0] ext4;

  fma_sum_scale #(.PW(PW), .AW(AW), .EW(EW)) u_sum_scale (
    .clk(clk), .rst(rst), .v_i(v2), .prod_i(prod2), .addend_i(addend2),
    .form_i(f2), .scale_i(s2), .v_o(v4), .ext_o(ext4)
  );

  fma_round_sat #(.EW(EW), .DROP(DROP), .DW(DW)) u_round_sat (
    .clk(clk), .rst(rst), .v_i(v4), .ext_i(ext4), .v_o(out_valid),
    .res_o(out_result), .ovf_o(out_ovf), .inexact_o(out_inexact)
  );

  // Assertion support: edges seen since the last reset, saturating.
  logic [2:0] since_rst;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)                   since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'(LAT)) |-> (out_valid == $past(in_valid, 6))); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst_d |-> !out_valid); // R8
endmodule

// File: tb/tb_fma_shader_alu.sv
module tb_fma_shader_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_a = '0, in_b = '0, in_c = '0;
  logic [1:0]  in_form = '0;
  logic [2:0]  in_scale = '0;
  logic        out_valid, out_ovf, out_inexact;
  logic [15:0] out_result;

  always #4 clk = ~clk; // 125 MHz

  fma_shader_alu dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_c(in_c), .in_form(in_form), .in_scale(in_scale), .out_valid(out_valid),
    .out_result(out_result), .out_ovf(out_ovf), .out_inexact(out_inexact)
  );

  int checks = 0;
  int fails  = 0;
  bit started = 0;
  bit finished = 0;

  // Expectation for the operation currently being driven.
  logic [15:0] cur_r = '0;
  logic        cur_o = 0, cur_x = 0;
  string       cur_tag = "R9";

  // Ring of expectations, one entry per rising edge.
  logic        hv [16];
  logic [15:0] hr [16];
  logic        ho [16];
  logic        hx [16];
  string       ht [16];
  logic [3:0]  wr = '0;

  initial for (int i = 0; i < 16; i++) begin hv[i] = 0; ht[i] = "R8"; end

  function automatic longint round_ne(input longint s, input int d);
    longint q, rem, half;
    q    = s >>> d;
    rem  = s - (q <<< d);
    half = longint'(1) <<< (d - 1);
    if (rem > half || (rem == half && q[0])) q = q + 1;
    return q;
  endfunction

  function automatic void clamp(input longint q, output logic [15:0] r, output logic ov);
    ov = 0;
    if (q > 32767)       begin r = 16'h7FFF; ov = 1; end
    else if (q < -32768) begin r = 16'h8000; ov = 1; end
    else                 r = q[15:0];
  endfunction

  // Exact sum, scaled, rounded once.
  function automatic void model(input logic [15:0] a, b, c, input logic [1:0] f,
                                input logic [2:0] sc, output logic [15:0] r,
                                output logic ov, output logic ix);
    longint p, cc, s, q;
    int d;
    p  = longint'($signed(a)) * longint'($signed(b));
    cc = longint'($signed(c)) * 256;
    s  = (f[0] ? -p : p) + (f[1] ? -cc : cc);
    d  = sc[2] ? 8 + int'(sc[1:0]) : 8 - int'(sc[1:0]);
    q  = s >>> d;
    ix = (s - (q <<< d)) != 0;
    clamp(round_ne(s, d), r, ov);
  endfunction

  // Product rounded to Q8.8 first, then added (unscaled).
  function automatic logic [15:0] two_step(input logic [15:0] a, b, c, input logic [1:0] f);
    longint pr, v;
    logic [15:0] r;
    logic ov;
    pr = round_ne(longint'($signed(a)) * longint'($signed(b)), 8);
    v  = (f[0] ? -pr : pr) + (f[1] ? -longint'($signed(c)) : longint'($signed(c)));
    clamp(v, r, ov);
    return r;
  endfunction

  task automatic issue(input logic [15:0] a, b, c, input logic [1:0] f,
                       input logic [2:0] sc, input string tag);
    logic [15:0] r;
    logic ov, ix;
    @(negedge clk);
    model(a, b, c, f, sc, r, ov, ix);
    in_valid = 1; in_a = a; in_b = b; in_c = c; in_form = f; in_scale = sc;
    cur_r = r; cur_o = ov; cur_x = ix; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; cur_tag = "R9";
    end
  endtask

  // Directly computed expectation, checked against the model.
  task automatic expect_model(input logic [15:0] a, b, c, input logic [1:0] f,
                              input logic [2:0] sc, input logic [15:0] er,
                              input logic eo, input logic ex, input string tag);
    logic [15:0] r;
    logic ov, ix;
    model(a, b, c, f, sc, r, ov, ix);
    checks++;
    if (r !== er || ov !== eo || ix !== ex) begin
      fails++;
      $display("FAIL %s model got %h/%b/%b exp %h/%b/%b", tag, r, ov, ix, er, eo, ex);
    end
    issue(a, b, c, f, sc, tag);
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < 16; i++) begin hv[i] = 0; ht[i] = "R8"; end
    end else begin
      hv[wr] = in_valid; hr[wr] = cur_r; ho[wr] = cur_o; hx[wr] = cur_x; ht[wr] = cur_tag;
    end
    wr = wr + 4'd1;
  end

  always @(negedge clk) begin
    logic [3:0] ix;
    if (started && !finished) begin
      ix = wr - 4'd6;
      checks++;
      if (out_valid !== hv[ix]) begin
        fails++;
        $display("FAIL %s out_valid got %b exp %b (R7)", ht[ix], out_valid, hv[ix]);
      end else if (hv[ix]) begin
        checks++;
        if (out_result !== hr[ix] || out_ovf !== ho[ix] || out_inexact !== hx[ix]) begin
          fails++;
          $display("FAIL %s result/ovf/inexact got %h/%b/%b exp %h/%b/%b",
                   ht[ix], out_result, out_ovf, out_inexact, hr[ix], ho[ix], hx[ix]);
        end
      end
    end
  end

  function automatic logic [15:0] edge_val(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
      3: return 16'h0080;  4: return 16'hFF80;  5: return 16'h0100;
      6: return 16'h7FFF;  7: return 16'h8000;  8: return 16'h0180;
      9: return 16'hFE80; 10: return 16'h1234; default: return 16'hC3A5;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    checks++; // R8: reset state
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R8 out_valid during reset got %b exp 0", out_valid);
    end
    rst = 0;

    // R2: fused differs from two-step
    checks++;
    if (two_step(16'h0001, 16'h0080, 16'h0001, 2'd0) === 16'h0002) begin
      fails++; $display("FAIL R2 two-step got %h exp != 0002", two_step(16'h0001, 16'h0080, 16'h0001, 2'd0));
    end
    expect_model(16'h0001, 16'h0080, 16'h0001, 2'd0, 3'd0, 16'h0002, 0, 1, "R2");
    checks++;
    if (two_step(16'h0003, 16'h0080, 16'h0001, 2'd2) === 16'h0000) begin
      fails++; $display("FAIL R2 two-step got %h exp != 0000", two_step(16'h0003, 16'h0080, 16'h0001, 2'd2));
    end
    expect_model(16'h0003, 16'h0080, 16'h0001, 2'd2, 3'd0, 16'h0000, 0, 1, "R2");
    // R4: ties to even
    expect_model(16'h0001, 16'h0080, 16'h0000, 2'd0, 3'd0, 16'h0000, 0, 1, "R4");
    expect_model(16'h0003, 16'h0080, 16'h0000, 2'd0, 3'd0, 16'h0002, 0, 1, "R4");
    expect_model(16'h0003, 16'h0080, 16'h0000, 2'd1, 3'd0, 16'hFFFE, 0, 1, "R4");
    expect_model(16'h0001, 16'h0080, 16'h0000, 2'd1, 3'd0, 16'h0000, 0, 1, "R4");
    // R1: four forms, 2*1.5 with c=1
    expect_model(16'h0200, 16'h0180, 16'h0100, 2'd0, 3'd0, 16'h0400, 0, 0, "R1");
    expect_model(16'h0200, 16'h0180, 16'h0100, 2'd1, 3'd0, 16'hFE00, 0, 0, "R1");
    expect_model(16'h0200, 16'h0180, 16'h0100, 2'd2, 3'd0, 16'h0200, 0, 0, "R1");
    expect_model(16'h0200, 16'h0180, 16'h0100, 2'd3, 3'd0, 16'hFC00, 0, 0, "R1");
    // R3: scale codes on 1.0
    expect_model(16'h0100, 16'h0100, 16'h0000, 2'd0, 3'd3, 16'h0800, 0, 0, "R3");
    expect_model(16'h0100, 16'h0100, 16'h0000, 2'd0, 3'd4, 16'h0100, 0, 0, "R3");
    expect_model(16'h0100, 16'h0100, 16'h0000, 2'd0, 3'd7, 16'h0020, 0, 0, "R3");
    // R5: rails and deferred overflow
    expect_model(16'h1000, 16'h0100, 16'h0000, 2'd0, 3'd3, 16'h7FFF, 1, 0, "R5");
    expect_model(16'h1000, 16'h0100, 16'h0000, 2'd1, 3'd3, 16'h8000, 0, 0, "R5");
    expect_model(16'h4000, 16'h0300, 16'hBF00, 2'd0, 3'd0, 16'h7F00, 0, 0, "R5");
    expect_model(16'h8000, 16'h8000, 16'h7FFF, 2'd3, 3'd7, 16'h8000, 1, 1, "R5");
    // R6: divide exposes discarded bits
    expect_model(16'h0000, 16'h0000, 16'h0002, 2'd0, 3'd5, 16'h0001, 0, 0, "R6");
    expect_model(16'h0000, 16'h0000, 16'h0003, 2'd0, 3'd5, 16'h0002, 0, 1, "R6");
    // R9: bubbles between operations
    for (int i = 0; i < 6; i++) begin
      issue(edge_val(i), edge_val(i + 3), edge_val(11 - i), 2'(i), 3'(i), "R9");
      idle(1);
    end
    // R7 R1 R3 R4 R5 R6: back-to-back sweep over edge values
    for (int ia = 0; ia < 12; ia++)
      for (int ib = 0; ib < 12; ib++)
        for (int ic = 0; ic < 6; ic++)
          for (int f = 0; f < 4; f++)
            for (int sc = 0; sc < 8; sc++)
              issue(edge_val(ia), edge_val(ib), edge_val(ic == 5 ? 3 : ic == 4 ? 7 : ic == 3 ? 6 : ic),
                    2'(f), 3'(sc), "R7");
    // R8: reset with operations in flight
    for (int i = 0; i < 3; i++) issue(16'h0100, edge_val(i + 5), 16'h0001, 2'd0, 3'd1, "R8");
    @(negedge clk);
    rst = 1; in_valid = 0; cur_tag = "R8";
    repeat (2) @(negedge clk);
    rst = 0;
    idle(10);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule